// File: doc/BRIEF.md
# IP Packet Pad and Trailer Inserter

This block prepares a stream of IP packets for cutting into 48-byte cell payloads. Bytes arrive one per cycle with a valid flag and a start-of-packet flag. The block reads the 16-bit total-length field from each header and works out how many zero bytes must be inserted. It passes the packet bytes through a short byte FIFO. After the last byte it emits the zero pad and then a four-byte trailer. The pad count leaves room for an eight-byte tail: the four trailer bytes here plus a four-byte check value that a later stage appends. Payload, pad and that tail therefore fill a whole number of cells.

A controller raises an end-of-packet strobe together with the final byte of each packet. The next packet may begin while the previous one is still emitting its pad and trailer. Its bytes wait in the FIFO until the trailer is out, so the two packets never interleave on the output. The pad length comes from the header field alone. The end-of-packet strobe only marks where the payload stops.

Top module: `ip_pad_trailer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `trailer_done` are 0.
- R2: Payload bytes leave in arrival order. When the output is idle, a byte presented with `in_valid` in cycle k appears on `out_data` with `out_valid` high in cycle k+2.
- R3: The length L is built from the bytes at positions 2 (high byte) and 3 (low byte), where position 0 is the byte marked with `in_sop`.
- R4: Directly after the final payload byte (the one marked with `ctl_eop`), exactly (48 - ((L + 8) mod 48)) mod 48 bytes of value 0x00 are emitted, one per cycle.
- R5: Directly after the pad, four trailer bytes follow on consecutive cycles: 0x00 (user-to-user), 0x00 (common part indicator), L[15:8], L[7:0].
- R6: `trailer_done` is a one-cycle pulse, high in the same cycle as the final trailer byte, and never high without `out_valid`.
- R7: `out_valid` is 0 in every cycle in which no byte is forwarded, for example while input bytes arrive with idle cycles between them.
- R8: A packet that starts while the previous packet's pad or trailer is still going out is held back until that trailer is complete. The previous trailer still carries its own length.
- R9: The FIFO holds 8 bytes. A following packet may fill it to exactly 8 entries during a stall and lose no byte. Writing while 8 entries are held and no byte is being read is a usage error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_data | input | 8 | Input packet byte |
| ctl_eop | input | 1 | Controller strobe: this input byte is the last payload byte |
| out_valid | output | 1 | Output byte present this cycle |
| out_data | output | 8 | Payload, pad or trailer byte |
| trailer_done | output | 1 | Pulse with the final trailer byte |

## Verification
Two things can happen in the same cycle here. Header bytes of a new packet can be captured while the previous packet's pad or trailer is still being emitted. The FIFO can also be written at full occupancy in the very cycle the output resumes reading. The bench provokes the first case by sending a packet with 20 bytes of pad, followed at once by a slowly paced packet. Its header lands during the stall, and the bench checks that each trailer carries its own packet's length. It provokes the second case with a 37-byte packet (3 pad bytes) followed by a packet sent without gaps, which fills the FIFO to exactly eight. The whole output stream is then compared byte by byte against one computed from the requirements.

// File: rtl/ip_pad_trailer.sv
module ip_pad_trailer #(
  parameter int DEPTH = 8,
  parameter int CELL  = 48,
  parameter int TAIL  = 8,
  parameter logic [7:0] UU_BYTE  = 8'h00,
  parameter logic [7:0] CPI_BYTE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sop,
  input  logic [7:0] in_data,
  input  logic       ctl_eop,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       trailer_done
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(CELL);
  localparam logic [1:0] S_PASS = 2'd0, S_PAD = 2'd1, S_TRL = 2'd2;

  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [1:0]    state;
  logic [PW-1:0] pcnt;
  logic [1:0]    tcnt;
  logic [2:0]    hidx;
  logic [15:0]   len_in, len_hold, len_act;

  wire [2:0]  pos  = in_sop ? 3'd0 : hidx;
  wire        rd   = (state == S_PASS) && (cnt != '0);
  wire        wr   = in_valid;
  wire [8:0]  head = mem[rp];

  wire [16:0]   tail_sum = {1'b0, len_hold} + 17'(TAIL);
  wire [16:0]   tail_rem = tail_sum % 17'(CELL);
  wire [PW-1:0] pad_calc = (tail_rem == '0) ? '0 : PW'(17'(CELL) - tail_rem);

  logic [7:0] trl_byte;
  always_comb begin
    case (tcnt)
      2'd0:    trl_byte = UU_BYTE;
      2'd1:    trl_byte = CPI_BYTE;
      2'd2:    trl_byte = len_act[15:8];
      default: trl_byte = len_act[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= {ctl_eop, in_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      hidx <= 3'd4; len_in <= '0; len_hold <= '0;
    end else begin
      if (wr) wp <= wp + 1'b1;
      if (rd) rp <= rp + 1'b1;
      cnt <= cnt + CW'(wr) - CW'(rd);
      if (in_valid) begin
        hidx <= (pos == 3'd4) ? 3'd4 : pos + 3'd1;
        if (pos == 3'd2) len_in[15:8] <= in_data;
        if (pos == 3'd3) len_in[7:0]  <= in_data;
        if (ctl_eop)     len_hold     <= len_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_PASS; pcnt <= '0; tcnt <= '0; len_act <= '0;
      out_valid <= 1'b0; out_data <= '0; trailer_done <= 1'b0;
    end else begin
      out_valid    <= 1'b0;
      trailer_done <= 1'b0;
      case (state)
        S_PASS: if (rd) begin
          out_valid <= 1'b1;
          out_data  <= head[7:0];
          if (head[8]) begin
            len_act <= len_hold;
            tcnt    <= '0;
            pcnt    <= pad_calc;
            state   <= (pad_calc != '0) ? S_PAD : S_TRL;
          end
        end
        S_PAD: begin
          out_valid <= 1'b1;
          out_data  <= 8'h00;
          pcnt      <= pcnt - 1'b1;
          if (pcnt == PW'(1)) state <= S_TRL;
        end
        S_TRL: begin
          out_valid <= 1'b1;
          out_data  <= trl_byte;
          tcnt      <= tcnt + 1'b1;
          if (tcnt == 2'd3) begin
            trailer_done <= 1'b1;
            state        <= S_PASS;
          end
        end
        default: state <= S_PASS;
      endcase
    end
  end
endmodule

// File: rtl/ip_pad_trailer_chk.sv
module ip_pad_trailer_chk #(
  parameter int DEPTH = 8,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [7:0]    out_data,
  input logic          trailer_done,
  input logic [1:0]    st,
  input logic [CW-1:0] level
);
  localparam logic [1:0] S_PASS = 2'd0, S_PAD = 2'd1, S_TRL = 2'd2;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && level == CW'(DEPTH) && st != S_PASS));

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAD) |=> (out_valid && out_data == 8'h00));

  // R5
  trailer_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRL) |=> out_valid);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trailer_done |=> !trailer_done);

  // R6
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trailer_done |-> out_valid);

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PASS && level == '0) |=> !out_valid);
endmodule

bind ip_pad_trailer ip_pad_trailer_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_data(out_data), .trailer_done(trailer_done), .st(state), .level(cnt)
);

// File: tb/ip_pad_trailer_tb_top.sv
module ip_pad_trailer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, ctl_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, trailer_done;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  ip_pad_trailer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_data(in_data), .ctl_eop(ctl_eop), .out_valid(out_valid),
    .out_data(out_data), .trailer_done(trailer_done)
  );

  int n_chk = 0, n_fail = 0, stray = 0;
  logic [7:0] got[$], exp_b[$];
  bit got_d[$], exp_d[$];

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      got.push_back(out_data);
      got_d.push_back(trailer_done);
    end
    if (rst_n && trailer_done && !out_valid) stray++;
  end

  task automatic check(input bit ok, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  function automatic logic [7:0] pbyte(input int i, input int len, input int seed);
    if (i == 2) return len[15:8];
    if (i == 3) return len[7:0];
    return 8'((seed + i * 7) & 8'hff);
  endfunction

  task automatic send(input int len, input int nb, input int seed, input int gap,
                      input bit chk_lat, input bit chk_gap);
    int pad = (48 - ((len + 8) % 48)) % 48;
    for (int i = 0; i < nb; i++) begin
      if (chk_lat && i == 2)
        // R2
        check(out_valid && out_data == pbyte(0, len, seed), "R2 two-cycle latency",
              int'(out_data), int'(pbyte(0, len, seed)));
      in_valid = 1'b1; in_sop = (i == 0); ctl_eop = (i == nb - 1);
      in_data = pbyte(i, len, seed);
      exp_b.push_back(in_data); exp_d.push_back(1'b0);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; ctl_eop = 1'b0;
      for (int g = 1; g < gap; g++) begin
        @(negedge clk);
        if (chk_gap && g == 2 && i < nb - 1)
          // R7
          check(!out_valid, "R7 valid low in input gap", int'(out_valid), 0);
      end
    end
    for (int k = 0; k < pad; k++) begin exp_b.push_back(8'h00); exp_d.push_back(1'b0); end
    exp_b.push_back(8'h00);     exp_d.push_back(1'b0);
    exp_b.push_back(8'h00);     exp_d.push_back(1'b0);
    exp_b.push_back(len[15:8]); exp_d.push_back(1'b0);
    exp_b.push_back(len[7:0]);  exp_d.push_back(1'b1);
  endtask

  task automatic drain_and_compare(input string tag);
    int bad_b = -1, bad_d = -1;
    repeat (90) @(negedge clk);
    check(got.size() == exp_b.size(), {tag, " byte count"}, got.size(), exp_b.size());
    if (got.size() == exp_b.size()) begin
      for (int i = 0; i < got.size(); i++) begin
        if (bad_b < 0 && got[i] != exp_b[i]) bad_b = i;
        if (bad_d < 0 && got_d[i] != exp_d[i]) bad_d = i;
      end
      check(bad_b < 0, {tag, " stream bytes"}, (bad_b < 0) ? 0 : int'(got[bad_b]),
            (bad_b < 0) ? 0 : int'(exp_b[bad_b]));
      check(bad_d < 0, {tag, " R6 done position"}, bad_d, -1);
    end
    check(stray == 0, {tag, " R6 done without valid"}, stray, 0);
    got.delete(); got_d.delete(); exp_b.delete(); exp_d.delete(); stray = 0;
  endtask

  task automatic t_reset();
    // R1
    check(out_valid == 1'b0 && trailer_done == 1'b0, "R1 outputs low in reset",
          int'({out_valid, trailer_done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && trailer_done == 1'b0, "R1 outputs low after reset",
          int'({out_valid, trailer_done}), 0);
  endtask

  task automatic t_latency();
    send(40, 40, 3, 0, 1'b1, 1'b0);
    drain_and_compare("R2 R4 R5 len40 zero pad");
  endtask

  task automatic t_pad();
    send(20, 20, 11, 0, 1'b0, 1'b0);
    drain_and_compare("R4 len20 pad20");
    send(41, 41, 29, 0, 1'b0, 1'b0);
    drain_and_compare("R4 len41 pad47");
    send(88, 88, 5, 0, 1'b0, 1'b0);
    drain_and_compare("R4 len88 pad0");
  endtask

  task automatic t_header();
    send(65535, 24, 17, 0, 1'b0, 1'b0);
    drain_and_compare("R3 header ffff pad25");
    send(16'h0123, 20, 91, 0, 1'b0, 1'b0);
    drain_and_compare("R3 header 0123 pad37");
  endtask

  task automatic t_gaps();
    send(22, 22, 7, 4, 1'b0, 1'b1);
    drain_and_compare("R7 paced input");
  endtask

  task automatic t_overlap();
    send(20, 20, 13, 0, 1'b0, 1'b0);
    send(32, 32, 77, 4, 1'b0, 1'b0);
    drain_and_compare("R8 header during pad");
  endtask

  task automatic t_full();
    send(37, 37, 41, 0, 1'b0, 1'b0);
    send(20, 20, 99, 0, 1'b0, 1'b0);
    drain_and_compare("R9 fifo filled to eight");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    repeat (3) @(negedge clk);
    t_latency();
    t_pad();
    t_header();
    t_gaps();
    t_overlap();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule